// File: doc/BRIEF.md
# ECC Error Logging Register Unit

This unit sits next to the ECC decoder of a DRAM controller and keeps a small register view of what the decoder reports. The decoder gives it two one-cycle event pulses, one for correctable and one for uncorrectable errors. Each pulse comes with the failing address. The unit counts the events in saturating counters and keeps two addresses. For uncorrectable errors it keeps the address of the first one seen since the last clear. For correctable errors it keeps the address of the most recent one. It raises a level-high interrupt while an enabled counter is nonzero.

Software reaches the registers through a plain 32-bit register bus with address, write data, write enable, read enable and read data. Read data is combinational and is returned in the same cycle as the read enable. Every register other than the key is write-protected. A write of the magic value 0xFC600309 to the key register at offset 0x00 opens the other registers for writing. A write of any other value to the key closes them again. The usual service routine reads the status and both addresses, sets the clear bit, and then releases the clear bit.

Top module: `ecc_err_regs`

## Requirements
- R1: Offsets are 0x00 key, 0x04 configuration, 0x50 control/status, 0x58 uncorrectable address and 0x5C correctable address. Configuration bit 7 (ECC on) and bit 4 (1 = DDR4, 0 = DDR3) read back as written, and every other configuration bit reads 0. The key register reads 0. When read enable is low, read data is 0. After reset, all registers read 0 and the interrupt output is low.
- R2: The unit leaves reset locked. Writing 0xFC600309 to offset 0x00 unlocks it, and writing any other value there locks it again. While the unit is locked, writes to the configuration and control registers are dropped.
- R3: Each correctable event taken increments the 8-bit count in control bits 23:16.
- R4: Each uncorrectable event taken increments the 4-bit count in control bits 15:12.
- R5: The correctable count saturates at 255 and the uncorrectable count saturates at 15. Neither wraps.
- R6: The uncorrectable address register (0x58) captures the address of the first uncorrectable event taken while the uncorrectable count is 0. It holds that address until a clear.
- R7: The correctable address register (0x5C) takes the address of every correctable event taken.
- R8: Control bit 0 enables the correctable interrupt and bit 1 enables the uncorrectable interrupt. The interrupt output is high exactly while an enabled counter is nonzero.
- R9: Control bit 31 reads back as written. From the write that sets it until the write that releases it, both counts are 0 and no event is taken. While the bit is 1, the interrupt output is low.
- R10: While configuration bit 7 is 0, events change neither the counts nor the addresses.
- R11: When a correctable and an uncorrectable event arrive in the same cycle, both counts and both address registers update.
- R12: Writes to the two address registers and to the count fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Register byte offset |
| busWrData | input | 32 | Write data |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, valid in the read cycle |
| ceValid | input | 1 | Correctable error pulse |
| ceAddr | input | 32 | Address of the correctable error |
| ueValid | input | 1 | Uncorrectable error pulse |
| ueAddr | input | 32 | Address of the uncorrectable error |
| irq | output | 1 | Level-high interrupt |

## Verification
The bench drives both counters past their limits. A design whose counter wraps would read 0 after 256 or 16 events.

It sends several uncorrectable events with different addresses. A design that treats the register as "latest" would report the last address instead of the first.

It writes the clear bit in the same cycle as an event and sends events while the clear is held. A clear that takes effect a cycle late, or that does not hold, would leave nonzero counts and a live interrupt.

It also exercises the lock. It writes while locked, writes a wrong key after a right one, and writes to the read-only fields. Each of these writes must leave the register contents unchanged on read-back.

// File: rtl/ecc_err_pkg.sv
`timescale 1ns/1ps
package ecc_err_pkg;
  localparam int OFF_KEY    = 'h00;
  localparam int OFF_CFG    = 'h04;
  localparam int OFF_CTRL   = 'h50;
  localparam int OFF_UEADDR = 'h58;
  localparam int OFF_CEADDR = 'h5C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_KEY, SEL_CFG, SEL_CTRL, SEL_UEADDR, SEL_CEADDR
  } regSel_e;

  typedef struct packed {
    logic    cfgWr;
    logic    ctrlWr;
    regSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/ecc_err_ctrl.sv
`timescale 1ns/1ps
module ecc_err_ctrl
  import ecc_err_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'hFC600309
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output strobes_t          strb
);
  localparam logic [ADDR_W-1:0] A_KEY    = ADDR_W'(OFF_KEY);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_UEADDR = ADDR_W'(OFF_UEADDR);
  localparam logic [ADDR_W-1:0] A_CEADDR = ADDR_W'(OFF_CEADDR);

  regSel_e hitSel;
  logic    unlocked;

  always_comb begin
    case (busAddr)
      A_KEY:    hitSel = SEL_KEY;
      A_CFG:    hitSel = SEL_CFG;
      A_CTRL:   hitSel = SEL_CTRL;
      A_UEADDR: hitSel = SEL_UEADDR;
      A_CEADDR: hitSel = SEL_CEADDR;
      default:  hitSel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) unlocked <= 1'b0;
    else if (busWrEn && hitSel == SEL_KEY) unlocked <= (busWrData == UNLOCK_KEY);
  end

  always_comb begin
    strb.cfgWr  = busWrEn && unlocked && (hitSel == SEL_CFG);
    strb.ctrlWr = busWrEn && unlocked && (hitSel == SEL_CTRL);
    strb.rdSel  = busRdEn ? hitSel : SEL_NONE;
  end

  // R2
  wrong_key_locks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && hitSel == SEL_KEY && busWrData != UNLOCK_KEY) |=> (!strb.cfgWr && !strb.ctrlWr));
endmodule

// File: rtl/ecc_err_dp.sv
`timescale 1ns/1ps
module ecc_err_dp
  import ecc_err_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int EADDR_W = 32,
  parameter int CE_W    = 8,
  parameter int UE_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic               ceValid,
  input  logic [EADDR_W-1:0] ceAddr,
  input  logic               ueValid,
  input  logic [EADDR_W-1:0] ueAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);
  localparam logic [CE_W-1:0] CE_MAX = {CE_W{1'b1}};
  localparam logic [UE_W-1:0] UE_MAX = {UE_W{1'b1}};
  localparam int CE_LSB = 16;
  localparam int UE_LSB = 12;

  logic               eccOn, ddr4Sel, clrHeld, clrNext;
  logic [1:0]         intEn;
  logic [CE_W-1:0]    ceCnt;
  logic [UE_W-1:0]    ueCnt;
  logic [EADDR_W-1:0] ueAddrReg, ceAddrReg;
  logic               takeCe, takeUe;

  assign clrNext = strb.ctrlWr ? busWrData[31] : clrHeld;
  assign takeCe  = ceValid && eccOn && !clrNext;
  assign takeUe  = ueValid && eccOn && !clrNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eccOn   <= 1'b0;
      ddr4Sel <= 1'b0;
      intEn   <= '0;
      clrHeld <= 1'b0;
    end else begin
      if (strb.cfgWr) begin
        eccOn   <= busWrData[7];
        ddr4Sel <= busWrData[4];
      end
      if (strb.ctrlWr) begin
        intEn   <= busWrData[1:0];
        clrHeld <= busWrData[31];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceCnt     <= '0;
      ueCnt     <= '0;
      ueAddrReg <= '0;
      ceAddrReg <= '0;
    end else if (clrNext) begin
      ceCnt <= '0;
      ueCnt <= '0;
    end else begin
      if (takeCe) begin
        ceAddrReg <= ceAddr;
        if (ceCnt != CE_MAX) ceCnt <= ceCnt + CE_W'(1);
      end
      if (takeUe) begin
        if (ueCnt == '0) ueAddrReg <= ueAddr;
        if (ueCnt != UE_MAX) ueCnt <= ueCnt + UE_W'(1);
      end
    end
  end

  assign irq = (intEn[0] && ceCnt != '0) || (intEn[1] && ueCnt != '0);

  always_comb begin
    rdData = '0;
    case (strb.rdSel)
      SEL_CFG: begin
        rdData[7] = eccOn;
        rdData[4] = ddr4Sel;
      end
      SEL_CTRL: begin
        rdData[31]               = clrHeld;
        rdData[CE_LSB +: CE_W]   = ceCnt;
        rdData[UE_LSB +: UE_W]   = ueCnt;
        rdData[1:0]              = intEn;
      end
      SEL_UEADDR: rdData[EADDR_W-1:0] = ueAddrReg;
      SEL_CEADDR: rdData[EADDR_W-1:0] = ceAddrReg;
      default:    rdData = '0;
    endcase
  end

  // R5
  ce_saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ceCnt == CE_MAX && !clrNext) |=> (ceCnt == CE_MAX));
  // R5
  ue_saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ueCnt == UE_MAX && !clrNext) |=> (ueCnt == UE_MAX));
  // R6
  ue_first_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ueCnt != '0) |=> $stable(ueAddrReg));
  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrHeld |-> (ceCnt == '0 && ueCnt == '0 && !irq));
  // R10
  ecc_off_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!eccOn && !strb.cfgWr) |=> ($stable(ceAddrReg) && $stable(ueAddrReg)));
endmodule

// File: rtl/ecc_err_regs.sv
`timescale 1ns/1ps
module ecc_err_regs
  import ecc_err_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int EADDR_W = 32,
  parameter int CE_W    = 8,
  parameter int UE_W    = 4,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'hFC600309
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic               busWrEn,
  input  logic               busRdEn,
  output logic [DATA_W-1:0]  busRdData,
  input  logic               ceValid,
  input  logic [EADDR_W-1:0] ceAddr,
  input  logic               ueValid,
  input  logic [EADDR_W-1:0] ueAddr,
  output logic               irq
);
  strobes_t strb;

  ecc_err_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNLOCK_KEY(UNLOCK_KEY)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .strb(strb)
  );

  ecc_err_dp #(.DATA_W(DATA_W), .EADDR_W(EADDR_W), .CE_W(CE_W), .UE_W(UE_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData),
    .ceValid(ceValid), .ceAddr(ceAddr), .ueValid(ueValid), .ueAddr(ueAddr),
    .rdData(busRdData), .irq(irq)
  );
endmodule

// File: tb/tb_ecc_err_regs.sv
`timescale 1ns/1ps
module tb_ecc_err_regs;
  localparam logic [31:0] KEY = 32'hFC600309;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        ceValid = 1'b0, ueValid = 1'b0;
  logic [31:0] ceAddr = '0, ueAddr = '0;
  logic        irq;

  int errors = 0;
  int checks = 0;

  // model state
  bit       mUnl, mEcc, mDdr4, mClr;
  bit [1:0] mEn;
  int       mCe, mUe;
  bit [31:0] mUeA, mCeA;

  always #5 clk = ~clk;

  ecc_err_regs dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData),
    .ceValid(ceValid), .ceAddr(ceAddr), .ueValid(ueValid), .ueAddr(ueAddr), .irq(irq)
  );

  function automatic bit [31:0] expCtrl();
    return {mClr, 7'b0, 8'(mCe), 4'(mUe), 10'b0, mEn};
  endfunction

  function automatic bit expIrq();
    return (mEn[0] && mCe != 0) || (mEn[1] && mUe != 0);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus, model updated at the clock edge
  task automatic tick(input bit wr, input bit [7:0] a, input bit [31:0] wd,
                      input bit ce, input bit [31:0] ca, input bit ue, input bit [31:0] ua);
    bit oldUnl, oldEcc, clrN;
    @(negedge clk);
    busWrEn = wr; busAddr = a; busWrData = wd;
    ceValid = ce; ceAddr = ca; ueValid = ue; ueAddr = ua;
    @(posedge clk);
    oldUnl = mUnl; oldEcc = mEcc; clrN = mClr;
    if (wr) begin
      if (a == 8'h00) mUnl = (wd == KEY);
      else if (oldUnl && a == 8'h04) begin mEcc = wd[7]; mDdr4 = wd[4]; end
      else if (oldUnl && a == 8'h50) begin mEn = wd[1:0]; mClr = wd[31]; clrN = wd[31]; end
    end
    if (clrN) begin mCe = 0; mUe = 0; end
    else if (oldEcc) begin
      if (ce) begin mCeA = ca; if (mCe < 255) mCe++; end
      if (ue) begin if (mUe == 0) mUeA = ua; if (mUe < 15) mUe++; end
    end
    #1;
    busWrEn = 1'b0; ceValid = 1'b0; ueValid = 1'b0;
  endtask

  task automatic rd(input bit [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic checkAll(input string req);
    logic [31:0] d;
    rd(8'h00, d); chk(req, "key", d, 32'h0);
    rd(8'h04, d); chk(req, "cfg", d, {24'b0, mEcc, 2'b0, mDdr4, 4'b0});
    rd(8'h50, d); chk(req, "ctrl", d, expCtrl());
    rd(8'h58, d); chk(req, "ueAddr", d, mUeA);
    rd(8'h5C, d); chk(req, "ceAddr", d, mCeA);
    chk(req, "irq", {31'b0, irq}, {31'b0, expIrq()});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R1 reset state
    checkAll("R1");
    // R1 read enable low gives zero
    @(negedge clk); busAddr = 8'h50; busRdEn = 1'b0; #1;
    chk("R1", "rdEn low", busRdData, 32'h0);
    // R2 locked writes dropped
    tick(1, 8'h04, 32'hFFFF_FFFF, 0, 0, 0, 0);
    tick(1, 8'h50, 32'h0000_0003, 0, 0, 0, 0);
    checkAll("R2");
    // R10 events while ECC off (unlock, enable irqs, keep ECC off)
    tick(1, 8'h00, KEY, 0, 0, 0, 0);
    tick(1, 8'h50, 32'h0000_0003, 0, 0, 0, 0);
    tick(0, 0, 0, 1, 32'h1111_0000, 1, 32'h2222_0000);
    checkAll("R10");
    // R1 config readback, other bits masked
    tick(1, 8'h04, 32'hFFFF_FF6F, 0, 0, 0, 0);
    checkAll("R1");
    tick(1, 8'h04, 32'h0000_0090, 0, 0, 0, 0);
    checkAll("R1");
    // R3 R7 correctable events
    tick(0, 0, 0, 1, 32'hA000_0010, 0, 0);
    tick(0, 0, 0, 1, 32'hA000_0020, 0, 0);
    checkAll("R3_R7");
    // R4 R6 uncorrectable: first address kept
    tick(0, 0, 0, 0, 0, 1, 32'hB000_0001);
    tick(0, 0, 0, 0, 0, 1, 32'hB000_0002);
    checkAll("R4_R6");
    // R11 simultaneous
    tick(0, 0, 0, 1, 32'hC000_0004, 1, 32'hC000_0008);
    checkAll("R11");
    // R12 writes to address regs and count fields have no effect
    tick(1, 8'h58, 32'hDEAD_BEEF, 0, 0, 0, 0);
    tick(1, 8'h5C, 32'hDEAD_BEEF, 0, 0, 0, 0);
    tick(1, 8'h50, 32'h00FF_F003, 0, 0, 0, 0);
    checkAll("R12");
    // R8 enables individually
    tick(1, 8'h50, 32'h0000_0000, 0, 0, 0, 0);
    checkAll("R8");
    tick(1, 8'h50, 32'h0000_0002, 0, 0, 0, 0);
    checkAll("R8");
    // R5 saturation
    for (int i = 0; i < 260; i++) tick(0, 0, 0, 1, 32'(i), (i < 20), 32'(i + 100));
    checkAll("R5");
    // R9 clear written alongside an event, held, then released
    tick(1, 8'h50, 32'h8000_0003, 1, 32'hE000_0000, 1, 32'hE000_0001);
    checkAll("R9");
    tick(0, 0, 0, 1, 32'hE000_0002, 1, 32'hE000_0003);
    checkAll("R9");
    tick(1, 8'h50, 32'h0000_0003, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 1, 32'hF000_0005);
    checkAll("R9_R6");
    // R2 wrong key relocks
    tick(1, 8'h00, ~KEY, 0, 0, 0, 0);
    tick(1, 8'h04, 32'h0000_0000, 0, 0, 0, 0);
    checkAll("R2");
    tick(1, 8'h00, KEY, 0, 0, 0, 0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      bit [31:0] w;
      op = int'($urandom_range(0, 19));
      w  = $urandom;
      case (op)
        0: tick(1, 8'h00, ($urandom_range(0, 3) != 0) ? KEY : w, 0, 0, 0, 0);
        1: tick(1, 8'h04, w | 32'h80, 0, 0, 0, 0);
        2: tick(1, 8'h04, w, 0, 0, 0, 0);
        3: tick(1, 8'h50, w & 32'h7FFF_FFFF, $urandom_range(0, 1), $urandom, 0, 0);
        4: tick(1, 8'h50, w, $urandom_range(0, 1), $urandom, $urandom_range(0, 1), $urandom);
        default: tick(0, 0, 0, $urandom_range(0, 1), $urandom, ($urandom_range(0, 3) == 0), $urandom);
      endcase
      if (n % 4 == 3) checkAll("R3_R4_R8");
    end
    checkAll("R5_R7");
    d = '0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule